// File: doc/BRIEF.md
# Serial Settings Command Parser

This block sits behind a UART receiver and in front of a UART transmitter. It takes one received byte at a time and parses short text commands. Each command is a command character, an equals sign, a decimal value and a carriage return. The parser checks the grammar, then checks the value against a per-setting legal range. Legal values are written into a bank of twelve settings registers, which drive the rest of the device. Every command gets a short ASCII answer: an acknowledge, or a numbered error code.

A special read-back command streams the whole settings bank out as text, one item per line, and then acknowledges. Replies go through a small byte FIFO. The receive side is stalled from the end of a command until its reply has fully left the FIFO, so replies never interleave. Both the byte input and the byte output use valid/ready handshakes. The serial line itself runs at 9600 baud, 8 data bits, no parity and 1 stop bit, with no flow control; that bit-level logic lives outside this block.

Top module: `serial_cmd_parser`

## Requirements
- R1: A command is a command character, then '=' (0x3D), then one or more ASCII digits, then CR (0x0D); the value is read as decimal, and leading zeros are allowed. A valid command writes its setting and replies with the four bytes '>' 'O' 'K' CR (0x3E 0x4F 0x4B 0x0D).
- R2: The settings bank has twelve 16-bit entries. Entry i sits at bits [16*i+15:16*i] of `settings_o`. The entries and their legal ranges, in index order, are: 'A' 0..20, 'B' 0..20, 'E' 0..1, 'G' 0..851, 'H' 0..10, 'I' 5..13000, 'M' 1..4, 'O' 0..15, 'P' 0..15, 'S' 0..2, 'T' 0..1, 'Y' 0..1. A value inside its range, bounds included, is stored.
- R3: A value outside the legal range of its setting is rejected with the reply '>' '1' CR. A value that goes above 65535 while its digits are still arriving also counts as out of range. A rejected command leaves every setting unchanged.
- R4: A syntax error gets the reply '>' '2' CR and changes nothing. A syntax error is any of these: a first character that is neither an upper-case letter nor '!', a second character other than '=', a non-digit in the value (space, tab or lower-case letter included), or no digits at all.
- R5: A command of up to 8 characters before CR is processed normally. When a 9th character arrives, the command is discarded: all input is ignored until the next CR, which then gets the reply '>' '3' CR. Nothing changes.
- R6: A well-formed command whose first character is an upper-case letter not listed in R2 gets the reply '>' '5' CR and changes nothing.
- R7: The command "!=3" returns every setting in index order. Each setting is sent as its letter, '=', its value in decimal without leading zeros (zero is sent as "0"), and CR. The list is followed by '>' 'O' 'K' CR. '!' with any other value gets '>' '1' CR.
- R8: When a command has more than one fault, only one error code is returned. The order is: too long (3), then syntax (2), then unknown letter (5), then out of range (1).
- R9: `rx_ready_o` is low from the cycle after a CR is accepted until the last reply byte has been taken. While `tx_valid_o` is high and `tx_ready_i` is low, `tx_data_o` holds its value.
- R10: After reset, `rx_ready_o` is high and `tx_valid_o` is low. Every setting holds the low end of its range: 'M' is 1, 'I' is 5, and all others are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_data_i | input | 8 | Received byte |
| rx_valid_i | input | 1 | Received byte is present |
| rx_ready_o | output | 1 | Parser accepts a byte this cycle |
| tx_data_o | output | 8 | Reply byte |
| tx_valid_o | output | 1 | Reply byte is present |
| tx_ready_i | input | 1 | Transmitter takes the reply byte |
| settings_o | output | 192 | Settings bank, 16 bits per entry, index order of R2 |

## Verification
The assertions assume that a byte is taken only on a cycle where both `rx_valid_i` and `rx_ready_o` are high. They also assume that the transmitter may hold `tx_ready_i` low for any number of cycles. Under those two conditions the reply FIFO can never overflow or underflow, and held reply data must stay stable. The stimulus presents a byte only after it has seen `rx_ready_o` high. It lowers `rx_valid_i` again straight after the accepting edge. It stalls the transmit side on purpose during one command, so the hold condition is actually exercised.

// File: rtl/cmd_pkg.sv
package cmd_pkg;

  localparam int NUM_SET = 12;

  typedef enum logic [3:0] {
    ST_RX, ST_DL, ST_DE, ST_DD, ST_DC, ST_GT, ST_C1, ST_C2, ST_CR
  } st_t;

  function automatic logic [7:0] set_letter(input int i);
    case (i)
      0: return "A";  1: return "B";  2: return "E";  3: return "G";
      4: return "H";  5: return "I";  6: return "M";  7: return "O";
      8: return "P";  9: return "S"; 10: return "T"; 11: return "Y";
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [15:0] set_lo(input int i);
    case (i)
      5: return 16'd5;
      6: return 16'd1;
      default: return 16'd0;
    endcase
  endfunction

  function automatic logic [15:0] set_hi(input int i);
    case (i)
      0, 1: return 16'd20;
      3: return 16'd851;
      4: return 16'd10;
      5: return 16'd13000;
      6: return 16'd4;
      7, 8: return 16'd15;
      9: return 16'd2;
      default: return 16'd1;
    endcase
  endfunction

  // binary to five packed BCD digits, most significant first
  function automatic logic [19:0] to_bcd(input logic [15:0] v);
    logic [35:0] s;
    s = {20'd0, v};
    for (int b = 0; b < 16; b++) begin
      for (int d = 0; d < 5; d++)
        if (s[16+4*d +: 4] >= 4'd5) s[16+4*d +: 4] = s[16+4*d +: 4] + 4'd3;
      s = s << 1;
    end
    return s[35:16];
  endfunction

endpackage

// File: rtl/reply_fifo.sv
module reply_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp_q, rp_q;

  assign empty_o = (wp_q == rp_q);
  assign full_o  = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
  assign dout_o  = mem[rp_q[AW-1:0]];

  always_ff @(posedge clk_i) begin
    if (push_i && !full_o) mem[wp_q[AW-1:0]] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (push_i && !full_o) wp_q <= wp_q + (AW+1)'(1);
      if (pop_i && !empty_o) rp_q <= rp_q + (AW+1)'(1);
    end
  end

  a_r9_no_overflow:  assert property (@(posedge clk_i) disable iff (!rst_ni) push_i |-> !full_o);
  a_r9_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni) pop_i |-> !empty_o);

endmodule

// File: rtl/cmd_lexer.sv
module cmd_lexer #(
  parameter int MAX_LEN = 8,
  parameter int W       = 16,
  parameter int AW      = 17
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [7:0]   byte_i,
  input  logic         take_i,
  output logic         eol_o,
  output logic [7:0]   letter_o,
  output logic [W-1:0] value_o,
  output logic         ovf_o,
  output logic         syn_o,
  output logic         long_o
);
  localparam int LW = $clog2(MAX_LEN + 1);
  localparam int XW = AW + 4;
  localparam logic [XW-1:0] LIMIT = XW'((2 ** W) - 1);

  logic [LW-1:0] len_q;
  logic [7:0]    letter_q;
  logic [AW-1:0] acc_q;
  logic          ovf_q, syn_q, long_q;

  logic is_cr, is_up, is_dig;
  logic [XW-1:0] acc_nxt;

  assign is_cr   = (byte_i == 8'h0D);
  assign is_up   = (byte_i >= "A") && (byte_i <= "Z");
  assign is_dig  = (byte_i >= "0") && (byte_i <= "9");
  assign acc_nxt = XW'(acc_q) * XW'(10) + XW'(byte_i[3:0]);
  assign eol_o   = take_i && is_cr;

  assign letter_o = letter_q;
  assign value_o  = acc_q[W-1:0];
  assign ovf_o    = ovf_q || acc_q[AW-1];
  assign syn_o    = syn_q || (len_q < LW'(3));
  assign long_o   = long_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= '0; letter_q <= '0; acc_q <= '0;
      ovf_q <= 1'b0; syn_q <= 1'b0; long_q <= 1'b0;
    end else if (take_i) begin
      if (is_cr) begin
        len_q <= '0; letter_q <= '0; acc_q <= '0;
        ovf_q <= 1'b0; syn_q <= 1'b0; long_q <= 1'b0;
      end else if (long_q) begin
        // discarding until CR
      end else if (len_q == LW'(MAX_LEN)) begin
        long_q <= 1'b1;
      end else begin
        len_q <= len_q + LW'(1);
        if (len_q == LW'(0)) begin
          if (is_up || byte_i == 8'h21) letter_q <= byte_i;
          else syn_q <= 1'b1;
        end else if (len_q == LW'(1)) begin
          if (byte_i != "=") syn_q <= 1'b1;
        end else if (is_dig) begin
          if (!ovf_q) begin
            if (acc_nxt > LIMIT) ovf_q <= 1'b1;
            else acc_q <= acc_nxt[AW-1:0];
          end
        end else begin
          syn_q <= 1'b1;
        end
      end
    end
  end

  a_r5_len_cap:     assert property (@(posedge clk_i) disable iff (!rst_ni) len_q <= LW'(MAX_LEN));
  a_r5_sticky_long: assert property (@(posedge clk_i) disable iff (!rst_ni) long_q && !eol_o |=> long_q);

endmodule

// File: rtl/setting_bank.sv
module setting_bank #(
  parameter int N = cmd_pkg::NUM_SET,
  parameter int W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [7:0]           letter_i,
  input  logic [W-1:0]         value_i,
  input  logic                 ovf_i,
  input  logic                 wr_i,
  output logic                 hit_o,
  output logic                 in_range_o,
  input  logic [$clog2(N)-1:0] rd_idx_i,
  output logic [7:0]           rd_letter_o,
  output logic [W-1:0]         rd_val_o,
  output logic [N*W-1:0]       flat_o
);
  import cmd_pkg::*;
  localparam int IW = $clog2(N);

  logic [N-1:0]   match, inr;
  logic [N*W-1:0] flat;

  for (genvar i = 0; i < N; i++) begin : g_set
    localparam logic [7:0]   LET = set_letter(i);
    localparam logic [W-1:0] LO  = W'(set_lo(i));
    localparam logic [W-1:0] HI  = W'(set_hi(i));
    logic [W-1:0] q;
    logic ge_lo;

    if (LO == '0) begin : g_nolo
      assign ge_lo = 1'b1;
    end else begin : g_lo
      assign ge_lo = (value_i >= LO);
    end

    assign match[i] = (letter_i == LET);
    assign inr[i]   = !ovf_i && ge_lo && (value_i <= HI);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= LO;
      else if (wr_i && match[i] && inr[i]) q <= value_i;
    end

    assign flat[i*W +: W] = q;

    a_r2_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni) q <= HI);
  end

  assign hit_o      = |match;
  assign in_range_o = |(match & inr);
  assign flat_o     = flat;

  always_comb begin
    rd_val_o    = '0;
    rd_letter_o = 8'h00;
    for (int i = 0; i < N; i++) begin
      if (rd_idx_i == IW'(i)) begin
        rd_val_o    = flat[i*W +: W];
        rd_letter_o = set_letter(i);
      end
    end
  end

  a_r3_no_bad_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
                                      wr_i && !in_range_o |=> $stable(flat_o));

endmodule

// File: rtl/serial_cmd_parser.sv
module serial_cmd_parser #(
  parameter int VAL_W      = 16,
  parameter int ACC_W      = 17,
  parameter int MAX_LEN    = 8,
  parameter int FIFO_DEPTH = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [7:0]                    rx_data_i,
  input  logic                          rx_valid_i,
  output logic                          rx_ready_o,
  output logic [7:0]                    tx_data_o,
  output logic                          tx_valid_o,
  input  logic                          tx_ready_i,
  output logic [cmd_pkg::NUM_SET*VAL_W-1:0] settings_o
);
  import cmd_pkg::*;
  localparam int N  = NUM_SET;
  localparam int IW = $clog2(N);

  st_t            st_q;
  logic [IW-1:0]  k_q;
  logic [2:0]     j_q;
  logic [7:0]     code_q;

  logic             take, eol, ovf, syn, too_long, hit, inr;
  logic [7:0]       letter, rd_let;
  logic [VAL_W-1:0] value, rd_val;
  logic             v_dump, v_wr;
  logic [7:0]       v_code;
  logic [19:0]      bcd;
  logic [3:0]       dig;
  logic [2:0]       lead;
  logic             push, fifo_full, fifo_empty;
  logic [7:0]       push_byte;

  assign rx_ready_o = (st_q == ST_RX) && fifo_empty;
  assign take       = rx_valid_i && rx_ready_o;

  cmd_lexer #(.MAX_LEN(MAX_LEN), .W(VAL_W), .AW(ACC_W)) u_lex (
    .clk_i, .rst_ni, .byte_i(rx_data_i), .take_i(take),
    .eol_o(eol), .letter_o(letter), .value_o(value),
    .ovf_o(ovf), .syn_o(syn), .long_o(too_long)
  );

  // one verdict per command, fixed priority
  always_comb begin
    v_code = 8'h00;
    v_dump = 1'b0;
    v_wr   = 1'b0;
    if (too_long)              v_code = "3";
    else if (syn)              v_code = "2";
    else if (letter == 8'h21) begin
      if (!ovf && value == VAL_W'(3)) v_dump = 1'b1;
      else                            v_code = "1";
    end
    else if (!hit)             v_code = "5";
    else if (!inr)             v_code = "1";
    else                       v_wr   = 1'b1;
  end

  setting_bank #(.N(N), .W(VAL_W)) u_bank (
    .clk_i, .rst_ni, .letter_i(letter), .value_i(value), .ovf_i(ovf),
    .wr_i(eol && v_wr), .hit_o(hit), .in_range_o(inr),
    .rd_idx_i(k_q), .rd_letter_o(rd_let), .rd_val_o(rd_val), .flat_o(settings_o)
  );

  assign bcd = to_bcd(16'(rd_val));

  always_comb begin
    if (bcd[19:16] != 4'd0)      lead = 3'd0;
    else if (bcd[15:12] != 4'd0) lead = 3'd1;
    else if (bcd[11:8] != 4'd0)  lead = 3'd2;
    else if (bcd[7:4] != 4'd0)   lead = 3'd3;
    else                         lead = 3'd4;
  end

  always_comb begin
    case (j_q)
      3'd0:    dig = bcd[19:16];
      3'd1:    dig = bcd[15:12];
      3'd2:    dig = bcd[11:8];
      3'd3:    dig = bcd[7:4];
      default: dig = bcd[3:0];
    endcase
  end

  always_comb begin
    case (st_q)
      ST_DL:   push_byte = rd_let;
      ST_DE:   push_byte = "=";
      ST_DD:   push_byte = {4'h3, dig};
      ST_GT:   push_byte = ">";
      ST_C1:   push_byte = (code_q == 8'h00) ? "O" : code_q;
      ST_C2:   push_byte = "K";
      default: push_byte = 8'h0D;
    endcase
  end

  assign push = (st_q != ST_RX) && !fifo_full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_RX;
      k_q    <= '0;
      j_q    <= '0;
      code_q <= '0;
    end else if (st_q == ST_RX) begin
      if (eol) begin
        if (v_dump) begin
          st_q <= ST_DL;
          k_q  <= '0;
        end else begin
          st_q   <= ST_GT;
          code_q <= v_code;
        end
      end
    end else if (push) begin
      case (st_q)
        ST_DL: st_q <= ST_DE;
        ST_DE: begin st_q <= ST_DD; j_q <= lead; end
        ST_DD: if (j_q == 3'd4) st_q <= ST_DC; else j_q <= j_q + 3'd1;
        ST_DC: begin
          if (k_q == IW'(N - 1)) begin
            st_q   <= ST_GT;
            code_q <= '0;
          end else begin
            k_q  <= k_q + IW'(1);
            st_q <= ST_DL;
          end
        end
        ST_GT: st_q <= ST_C1;
        ST_C1: st_q <= (code_q == 8'h00) ? ST_C2 : ST_CR;
        ST_C2: st_q <= ST_CR;
        default: st_q <= ST_RX;
      endcase
    end
  end

  reply_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
    .clk_i, .rst_ni, .push_i(push), .din_i(push_byte),
    .pop_i(tx_valid_o && tx_ready_i), .dout_o(tx_data_o),
    .full_o(fifo_full), .empty_o(fifo_empty)
  );

  assign tx_valid_o = !fifo_empty;

  a_r9_tx_hold:  assert property (@(posedge clk_i) disable iff (!rst_ni)
                                  tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));
  a_r9_rx_stall: assert property (@(posedge clk_i) disable iff (!rst_ni) eol |=> !rx_ready_o);
  a_r7_dump_idx: assert property (@(posedge clk_i) disable iff (!rst_ni)
                                  st_q == ST_DL |-> k_q < IW'(N));

endmodule

// File: tb/serial_cmd_parser_test.sv
module serial_cmd_parser_test;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_ni, rx_valid, rx_ready, tx_valid, tx_ready;
  logic [7:0]   rx_data, tx_data;
  logic [191:0] settings;

  serial_cmd_parser uut (
    .clk_i(clk), .rst_ni(rst_ni), .rx_data_i(rx_data), .rx_valid_i(rx_valid),
    .rx_ready_o(rx_ready), .tx_data_o(tx_data), .tx_valid_o(tx_valid),
    .tx_ready_i(tx_ready), .settings_o(settings)
  );

  logic [15:0] sv [12];
  for (genvar g = 0; g < 12; g++) begin : g_sv
    assign sv[g] = settings[g*16 +: 16];
  end

  localparam logic [7:0]  LET [12] = '{"A","B","E","G","H","I","M","O","P","S","T","Y"};
  localparam logic [15:0] RST [12] = '{16'd0,16'd0,16'd0,16'd0,16'd0,16'd5,16'd1,16'd0,16'd0,16'd0,16'd0,16'd0};

  typedef struct packed {
    logic [95:0] cmd;
    logic [31:0] rep;
    logic [3:0]  idx;
    logic [15:0] val;
    logic [15:0] req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VEC [NV] = '{
    '{96'("G=851"),          32'(">OK\015"), 4'd3,  16'd851,   "R1"},
    '{96'("G=852"),          32'(">1\015"),  4'd3,  16'd851,   "R3"},
    '{96'("A=20"),           32'(">OK\015"), 4'd0,  16'd20,    "R2"},
    '{96'("A=21"),           32'(">1\015"),  4'd0,  16'd20,    "R3"},
    '{96'("M=0"),            32'(">1\015"),  4'd6,  16'd1,     "R3"},
    '{96'("M=4"),            32'(">OK\015"), 4'd6,  16'd4,     "R2"},
    '{96'("I=4"),            32'(">1\015"),  4'd5,  16'd5,     "R3"},
    '{96'("I=13000"),        32'(">OK\015"), 4'd5,  16'd13000, "R2"},
    '{96'("I=99999"),        32'(">1\015"),  4'd5,  16'd13000, "R3"},
    '{96'("g=3"),            32'(">2\015"),  4'd3,  16'd851,   "R4"},
    '{96'("G =3"),           32'(">2\015"),  4'd3,  16'd851,   "R4"},
    '{96'("G=\0113"),        32'(">2\015"),  4'd3,  16'd851,   "R4"},
    '{96'("G3"),             32'(">2\015"),  4'd3,  16'd851,   "R4"},
    '{96'("G="),             32'(">2\015"),  4'd3,  16'd851,   "R4"},
    '{96'("S=1a"),           32'(">2\015"),  4'd9,  16'd0,     "R4"},
    '{96'("Q=5"),            32'(">5\015"),  4'd3,  16'd851,   "R6"},
    '{96'("Q=x"),            32'(">2\015"),  4'd3,  16'd851,   "R8"},
    '{96'("G=000000007"),    32'(">3\015"),  4'd3,  16'd851,   "R5"},
    '{96'("Z=1234567"),      32'(">3\015"),  4'd3,  16'd851,   "R8"},
    '{96'("G=000012"),       32'(">OK\015"), 4'd3,  16'd12,    "R5"},
    '{96'("H=10"),           32'(">OK\015"), 4'd4,  16'd10,    "R2"},
    '{96'("Y=01"),           32'(">OK\015"), 4'd11, 16'd1,     "R1"},
    '{96'("!=2"),            32'(">1\015"),  4'd3,  16'd12,    "R7"},
    '{96'("O=15"),           32'(">OK\015"), 4'd7,  16'd15,    "R2"},
    '{96'("P=16"),           32'(">1\015"),  4'd8,  16'd0,     "R3"},
    '{96'("E=1"),            32'(">OK\015"), 4'd2,  16'd1,     "R2"},
    '{96'("B=7"),            32'(">OK\015"), 4'd1,  16'd7,     "R1"}
  };

  int          n_tests = 0;
  int          n_fail  = 0;
  logic [7:0]  cap [256];
  int          cap_n   = 0;
  logic [15:0] model [12];

  always begin
    @(negedge clk);
    #1;
    if (tx_valid && tx_ready && cap_n < 256) begin
      cap[8'(cap_n)] = tx_data;
      cap_n = cap_n + 1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail = n_fail + 1;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  function automatic string pk2str(input logic [95:0] s);
    string r = "";
    logic [95:0] t = s;
    for (int i = 0; i < 12; i++) begin
      if (t[95:88] != 8'h00) r = $sformatf("%s%c", r, t[95:88]);
      t = t << 8;
    end
    return r;
  endfunction

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    while (!rx_ready) @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!rx_ready) @(negedge clk);
    #2;
  endtask

  task automatic send_cmd(input logic [95:0] c);
    logic [95:0] t = c;
    for (int i = 0; i < 12; i++) begin
      if (t[95:88] != 8'h00) send_byte(t[95:88]);
      t = t << 8;
    end
    send_byte(8'h0D);
  endtask

  task automatic check_reply(input string exp, input string req);
    string got = "";
    for (int i = 0; i < cap_n; i++) got = $sformatf("%s%c", got, cap[8'(i)]);
    n_tests = n_tests + 1;
    if (got != exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s reply: got \"%s\" expected \"%s\"", req, got, exp);
    end
  endtask

  task automatic check_set(input logic [3:0] idx, input string req);
    n_tests = n_tests + 1;
    if (sv[idx] !== model[idx]) begin
      n_fail = n_fail + 1;
      $display("FAIL %s setting %0d: got %0d expected %0d", req, idx, sv[idx], model[idx]);
    end
  endtask

  task automatic check_bit(input logic got, input logic exp, input string what);
    n_tests = n_tests + 1;
    if (got !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: got %b expected %b", what, got, exp);
    end
  endtask

  initial begin
    string exp;
    logic [7:0] held;
    rst_ni = 1'b0; rx_valid = 1'b0; rx_data = 8'h00; tx_ready = 1'b1;
    for (int i = 0; i < 12; i++) model[i] = RST[i];
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R10 reset state
    check_bit(rx_ready, 1'b1, "R10 rx_ready after reset");
    check_bit(tx_valid, 1'b0, "R10 tx_valid after reset");
    for (int i = 0; i < 12; i++) check_set(4'(i), "R10");

    for (int v = 0; v < NV; v++) begin
      cap_n = 0;
      send_cmd(VEC[v].cmd);
      wait_idle();
      check_reply(pk2str({64'd0, VEC[v].rep}), $sformatf("%s", VEC[v].req));
      model[VEC[v].idx] = VEC[v].val;
      check_set(VEC[v].idx, $sformatf("%s", VEC[v].req));
    end

    // R9 transmit stall holds data and blocks receive
    @(negedge clk);
    tx_ready = 1'b0;
    cap_n = 0;
    send_cmd(96'("T=1"));
    repeat (3) @(negedge clk);
    check_bit(tx_valid, 1'b1, "R9 tx_valid while stalled");
    check_bit(tx_data == ">", 1'b1, "R9 first reply byte");
    check_bit(rx_ready, 1'b0, "R9 rx_ready low during reply");
    held = tx_data;
    repeat (4) @(negedge clk);
    check_bit(tx_data == held, 1'b1, "R9 tx_data stable");
    check_bit(rx_ready, 1'b0, "R9 rx_ready still low");
    tx_ready = 1'b1;
    wait_idle();
    check_reply(">OK\015", "R9");
    model[10] = 16'd1;
    check_set(4'd10, "R9");

    // R7 full read-back
    cap_n = 0;
    send_cmd(96'("!=3"));
    wait_idle();
    exp = "";
    for (int i = 0; i < 12; i++)
      exp = $sformatf("%s%c=%0d%c", exp, LET[4'(i)], model[4'(i)], 8'h0D);
    exp = $sformatf("%s>OK%c", exp, 8'h0D);
    check_reply(exp, "R7");

    for (int i = 0; i < 12; i++) check_set(4'(i), "R2");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule